// File: doc/BRIEF.md
# Write-Protected Self-Timed Programming Sequencer

This block sits behind the serial front-end of a small non-volatile word store. The front-end decodes each instruction and presents its operation, address and data word, and raises a completion flag once the last bit has arrived. The sequencer acts only at the moment chip select is seen falling. At that moment it updates a programming-enable latch, or it launches an internal program cycle that runs from its own counter of system clocks. No serial clock edges are needed after that point.

Erase, write, erase-all and write-all are refused while the enable latch is clear. A single-word write erases the word to all ones at the start of the cycle and stores the new data at the end. Erase-all and write-all act on every word of the register array. While a cycle runs, the data-out line reports busy (low) whenever chip select is high. Once the cycle ends it reports ready (high). The data-out line is released at the next falling edge of chip select. A read port lets the front-end, and the bench, fetch any word.

Top module: `nv_prog_seq`

## Requirements
- R1: After reset the enable latch is clear, `busy_o` is 0, `do_oe_o` is 0, and every word of the array reads 0.
- R2: While the enable latch is clear, completed erase, write, erase-all and write-all commands leave the array unchanged and `busy_o` stays 0.
- R3: A completed enable command (`cmd_op_i`=2) sets the latch. The latch stays set until a completed disable command (`cmd_op_i`=3) or a reset.
- R4: A command counts only when `cmd_done_i` is high in the clock where `cs_i` is sampled low after being high. A programming command accepted this way raises `busy_o` from the next clock for exactly PROG_CYCLES clocks, with `cs_i` held low throughout.
- R5: From the start of a cycle until the next falling edge of `cs_i` seen while idle, `do_oe_o` equals `cs_i`. While it is driven, `do_o` is 0 while busy and 1 once the cycle has ended. At other times `do_oe_o` is 0.
- R6: Erase (`cmd_op_i`=4) sets the addressed word to all ones. Erase-all (`cmd_op_i`=6) sets every word to all ones.
- R7: Write (`cmd_op_i`=5) sets the addressed word to all ones when the cycle starts and stores `cmd_data_i` when `busy_o` falls.
- R8: Write-all (`cmd_op_i`=7) stores the same data word in every location when `busy_o` falls.
- R9: Commands that complete while `busy_o` is 1, including enable and disable, have no effect.
- R10: When `cs_i` falls with `cmd_done_i` low, no cycle starts and the latch is unchanged.
- R11: Read (`cmd_op_i`=1) and no-op (`cmd_op_i`=0) start no cycle and leave the latch and the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; drives the cycle timer |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select level |
| cmd_op_i | input | 3 | Decoded operation code |
| cmd_addr_i | input | AW | Decoded word address |
| cmd_data_i | input | DW | Decoded data word |
| cmd_done_i | input | 1 | Instruction fully received |
| rd_addr_i | input | AW | Array read address |
| rd_data_o | output | DW | Array read data |
| busy_o | output | 1 | Program cycle in progress |
| do_o | output | 1 | Ready (1) or busy (0) status bit |
| do_oe_o | output | 1 | Drive enable for the status bit |

## Verification
If the enable latch holds the wrong value, the next accepted programming command shows it at once. Either `busy_o` rises when it should stay low, or it stays low when it should rise, and the read port then shows the wrong word one cycle cycle later. A timer off by one changes the number of clocks that `busy_o` stays high and shifts the clock in which the final write appears on `rd_data_o`. A status phase that is set wrongly shows as `do_oe_o` disagreeing with `cs_i` at the next clock. The per-clock reference model therefore catches each of these faults within one clock of the first observable difference.

// File: rtl/nvps_pkg.sv
package nvps_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_READ  = 3'd1,
    OP_EWEN  = 3'd2,
    OP_EWDS  = 3'd3,
    OP_ERASE = 3'd4,
    OP_WRITE = 3'd5,
    OP_ERAL  = 3'd6,
    OP_WRAL  = 3'd7
  } op_e;

  function automatic logic is_prog(op_e op);
    return op inside {OP_ERASE, OP_WRITE, OP_ERAL, OP_WRAL};
  endfunction
endpackage

// File: rtl/nvps_wp_latch.sv
module nvps_wp_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_o <= 1'b0;
    else if (clr_i) en_o <= 1'b0;
    else if (set_i) en_o <= 1'b1;
  end

  // R3
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i && !clr_i |=> $stable(en_o));
endmodule

// File: rtl/nvps_timer.sv
module nvps_timer #(
  parameter int unsigned PROG_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      cnt_q  <= LAST;
    end else if (done_o) begin
      busy_o <= 1'b0;
    end else if (busy_o) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  // R4
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
endmodule

// File: rtl/nvps_array.sv
module nvps_array #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          all_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[g] <= '0;
      else if (we_i && (all_i || waddr_i == AW'(g)))
        mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/nv_prog_seq.sv
module nv_prog_seq
  import nvps_pkg::*;
#(
  parameter int unsigned AW          = 6,
  parameter int unsigned DW          = 16,
  parameter int unsigned PROG_CYCLES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic [2:0]    cmd_op_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_data_i,
  input  logic          cmd_done_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          busy_o,
  output logic          do_o,
  output logic          do_oe_o
);
  op_e           op_in, op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          cs_q, cs_fall, accept, start, done, en, stat_q;
  logic          we, we_all;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;

  assign op_in   = op_e'(cmd_op_i);
  assign cs_fall = cs_q && !cs_i;
  assign accept  = cs_fall && cmd_done_i && !busy_o;
  assign start   = accept && en && is_prog(op_in);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= 1'b0;
    else         cs_q <= cs_i;
  end

  nvps_wp_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (accept && op_in == OP_EWEN),
    .clr_i  (accept && op_in == OP_EWDS),
    .en_o   (en)
  );

  nvps_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy_o),
    .done_o  (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else if (start) begin
      op_q   <= op_in;
      addr_q <= cmd_addr_i;
      data_q <= cmd_data_i;
    end
  end

  // status phase: from cycle start until the next idle CS fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 stat_q <= 1'b0;
    else if (start)              stat_q <= 1'b1;
    else if (cs_fall && !busy_o) stat_q <= 1'b0;
  end

  assign do_oe_o = cs_i && stat_q;
  assign do_o    = !busy_o;

  // erase phase at start, program phase at end
  always_comb begin
    we     = 1'b0;
    we_all = 1'b0;
    waddr  = addr_q;
    wdata  = data_q;
    if (start && op_in inside {OP_ERASE, OP_WRITE, OP_ERAL}) begin
      we     = 1'b1;
      we_all = (op_in == OP_ERAL);
      waddr  = cmd_addr_i;
      wdata  = '1;
    end else if (done && op_q inside {OP_WRITE, OP_WRAL}) begin
      we     = 1'b1;
      we_all = (op_q == OP_WRAL);
    end
  end

  nvps_array #(.AW(AW), .DW(DW)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .all_i   (we_all),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  // R2
  locked_no_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall && cmd_done_i && !en && !busy_o |=> !busy_o);

  // R9
  busy_latch_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(en));

  // R10
  incomplete_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall && !cmd_done_i && !busy_o |=> !busy_o);

  // R5
  busy_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cs_i |-> do_oe_o && !do_o);

  // R4
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_fall && cmd_done_i));
endmodule

// File: tb/nv_prog_seq_tb.sv
module nv_prog_seq_tb;
  localparam int AW = 6, DW = 16, N = 8, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, done = 1'b0;
  logic [2:0] op = 3'd0;
  logic [AW-1:0] addr = '0, raddr = '0;
  logic [DW-1:0] data = '0, rdata;
  logic busy, dout, doe;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nv_prog_seq #(.AW(AW), .DW(DW), .PROG_CYCLES(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .cmd_op_i(op), .cmd_addr_i(addr),
    .cmd_data_i(data), .cmd_done_i(done), .rd_addr_i(raddr), .rd_data_o(rdata),
    .busy_o(busy), .do_o(dout), .do_oe_o(doe));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model
  logic m_csq, m_en, m_busy, m_stat;
  int m_left;
  logic [2:0] m_op;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;
  logic [DW-1:0] m_mem [DEPTH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_csq = 0; m_en = 0; m_busy = 0; m_stat = 0; m_left = 0; m_op = 0;
      for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    end else begin
      automatic logic fall = m_csq && !cs;
      automatic logic was_busy = m_busy;
      automatic logic started = 0;
      if (was_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0;
          if (m_op == 3'd5) m_mem[m_addr] = m_data;
          if (m_op == 3'd7) for (int i = 0; i < DEPTH; i++) m_mem[i] = m_data;
        end
      end else if (fall && done) begin
        if (op == 3'd2) m_en = 1;
        else if (op == 3'd3) m_en = 0;
        else if (op >= 3'd4 && m_en) begin
          started = 1; m_busy = 1; m_left = N; m_stat = 1;
          m_op = op; m_addr = addr; m_data = data;
          if (op == 3'd4 || op == 3'd5) m_mem[addr] = '1;
          if (op == 3'd6) for (int i = 0; i < DEPTH; i++) m_mem[i] = '1;
        end
      end
      if (fall && !was_busy && !started) m_stat = 0;
      m_csq = cs;
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    check("R4 busy", busy, m_busy);
    check("R5 oe", doe, cs && m_stat);
    if (doe) check("R5 do", dout, !m_busy);
    check("R6/R7/R8 rdata", rdata, m_mem[raddr]);
  end

  task automatic issue(logic [2:0] o, logic [AW-1:0] a, logic [DW-1:0] d, logic full);
    @(negedge clk); cs = 1; op = o; addr = a; data = d; done = full;
    @(negedge clk); @(negedge clk); cs = 0;
    @(negedge clk); done = 0; op = 0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic peek(string req, logic [AW-1:0] a, logic [DW-1:0] exp);
    raddr = a; #1; check(req, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 oe", doe, 0);
    peek("R1 array", 6'd9, 16'h0);

    // R2: locked
    issue(3'd5, 6'd5, 16'hA5A5, 1);
    check("R2 busy", busy, 0);
    issue(3'd6, 6'd0, 16'h0, 1);
    wait_ready();
    peek("R2 word", 6'd5, 16'h0);

    // R3 enable, R7 write with erase first
    issue(3'd2, 6'd0, 16'h0, 1);
    issue(3'd5, 6'd5, 16'hA5A5, 1);
    begin
      int cnt = 1;
      peek("R7 erased mid-cycle", 6'd5, 16'hFFFF);
      cs = 1; #1;
      check("R5 busy oe", doe, 1);
      check("R5 busy do", dout, 0);
      while (busy && cnt < 100) begin @(negedge clk); if (busy) cnt++; end
      check("R4 busy length", cnt, N);
    end
    check("R5 ready do", dout, 1);
    check("R5 ready oe", doe, 1);
    peek("R7 word", 6'd5, 16'hA5A5);
    @(negedge clk); cs = 0; @(negedge clk);
    check("R5 released", doe, 0);

    // R6 erase
    issue(3'd4, 6'd5, 16'h0, 1);
    wait_ready();
    peek("R6 erase", 6'd5, 16'hFFFF);

    // R9: commands while busy ignored
    issue(3'd5, 6'd3, 16'h1111, 1);
    issue(3'd3, 6'd0, 16'h0, 1);
    issue(3'd4, 6'd3, 16'h0, 1);
    wait_ready();
    peek("R9 first write kept", 6'd3, 16'h1111);
    issue(3'd5, 6'd4, 16'h2222, 1);
    check("R9 latch still set", busy, 1);
    wait_ready();
    peek("R9 write", 6'd4, 16'h2222);

    // R10 incomplete
    issue(3'd5, 6'd7, 16'h7777, 0);
    check("R10 busy", busy, 0);
    peek("R10 word", 6'd7, 16'h0);

    // R11 read/no-op
    issue(3'd1, 6'd3, 16'h0, 1);
    check("R11 busy", busy, 0);
    peek("R11 word", 6'd3, 16'h1111);

    // R8 write-all
    issue(3'd7, 6'd0, 16'h1234, 1);
    wait_ready();
    for (int i = 0; i < DEPTH; i++) peek("R8 readback", AW'(i), 16'h1234);

    // R6 erase-all
    issue(3'd6, 6'd0, 16'h0, 1);
    wait_ready();
    for (int i = 0; i < DEPTH; i++) peek("R6 readback", AW'(i), 16'hFFFF);

    // R3 disable, then reset clears enable
    issue(3'd3, 6'd0, 16'h0, 1);
    issue(3'd5, 6'd2, 16'h0, 1);
    check("R3 disabled", busy, 0);
    peek("R3 word", 6'd2, 16'hFFFF);
    issue(3'd2, 6'd0, 16'h0, 1);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    issue(3'd5, 6'd2, 16'h0, 1);
    check("R3 reset clears", busy, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule